// File: doc/BRIEF.md
# Keyed 64-bit Watchdog Timer

This block is a memory-mapped watchdog. It is built around a 64-bit up-counter that software reads and writes as two 32-bit words, and it has a 64-bit period that is set the same way. Software sets up the period and the count, releases both counter halves, and picks a run mode. It then arms the watchdog by writing two 16-bit keys, in a fixed order, into the upper half of the watchdog control word.

After the first key, the timer configuration is frozen. From then on only the key field and the clear of the expiry flag still respond to writes. Once armed, software must complete the same two-key service sequence again before the count reaches the period. If it does not, the block emits a one-cycle reset request and latches a sticky expiry flag.

The watchdog never disarms. Only a system reset returns it to idle. The bus is a plain 32-bit word bus: byte address, write enable, write data, and combinational read data.

Top module: `wdog64_keyed`

## Requirements
- R1: After reset, every counter, period, mode, global-control and flag bit reads 0, `rstReq` is low, and offset 0x00 reads the `ID_VALUE` parameter.
- R2: While idle, the registers read back what was written. Offsets 0x10 and 0x14 hold the count's low and high words, 0x18 and 0x1C the period's low and high words, 0x20 keeps only bits [7:6] (run mode), and 0x24 keeps only bits [3:0]. Offset 0x04 reads 0.
- R3: The 64-bit count rises by one per clock, carrying from the low word into the high word, exactly when mode bits [7:6] are nonzero and global-control bits 0 and 1 are both 1. Otherwise it holds.
- R4: From idle, a write to 0x28 with 0xA5C6 in bits [31:16] and bit 14 set locks the block. The same key with bit 14 clear leaves it idle. A following 0xDA7E arms it. Bit 14 of 0x28 reads 1 from the lock onward.
- R5: Once locked, writes to 0x10, 0x14, 0x18, 0x1C, 0x20 and 0x24 are ignored.
- R6: While armed, 0xA5C6 followed by 0xDA7E clears the count to 0 on the clock edge of the second write. Repeating this sequence within the period prevents any reset request.
- R7: A key of any other value, or a correct key out of order, leaves the key state unchanged. Once locked, the block never returns to idle except through reset.
- R8: When the block is armed, running, and count equals period, the next cycle shows `rstReq` high for one cycle, bit 15 of 0x28 set, and the count at 0. Successive requests are therefore period+1 cycles apart.
- R9: Writing 1 to bit 15 of 0x28 clears the expiry flag, also while locked. Key writes with bit 15 at 0 leave it set.
- R10: No reset request occurs while idle or after only the first key, even when the count passes the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the word accessed |
| busWe | input | 1 | Write strobe, sampled on the rising edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the address |
| rstReq | output | 1 | One-cycle reset request on expiry |

## Verification
A register write takes effect on the clock edge that samples `busWe`. Read data follows the address with no delay. The bench therefore changes inputs at falling edges and samples read data 1 ns after setting the address, so it sees the state left by the last edge. A service clear is checked by reading the count in the same half-cycle after the second key write, where it must be 0. The reset request is due on the edge after count equals period. A falling-edge monitor records each pulse, and the bench checks that the pulse lasts one cycle and that pulses are period+1 falling edges apart. The count-increment and carry checks read the count at consecutive falling edges, starting right after the enabling write, and expect +1 per edge.

// File: rtl/wdog64_pkg.sv
package wdog64_pkg;
  localparam logic [7:0] OFF_ID     = 8'h00;
  localparam logic [7:0] OFF_EMU    = 8'h04;
  localparam logic [7:0] OFF_CNT_LO = 8'h10;
  localparam logic [7:0] OFF_CNT_HI = 8'h14;
  localparam logic [7:0] OFF_PRD_LO = 8'h18;
  localparam logic [7:0] OFF_PRD_HI = 8'h1C;
  localparam logic [7:0] OFF_MODE   = 8'h20;
  localparam logic [7:0] OFF_GCTL   = 8'h24;
  localparam logic [7:0] OFF_WDCTL  = 8'h28;

  localparam logic [15:0] KEY_OPEN = 16'hA5C6;
  localparam logic [15:0] KEY_SEAL = 16'hDA7E;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACTIVE,
    ST_SERVICE
  } wdState_e;

  // strobes from the key controller to the datapath
  typedef struct packed {
    logic locked;
    logic armed;
    logic clrCount;
  } ctrlStrb_t;
endpackage

// File: rtl/wdog64_ctrl.sv
module wdog64_ctrl
  import wdog64_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        keyWr,
  input  logic [15:0] keyVal,
  input  logic        enBit,
  output ctrlStrb_t   strb
);
  wdState_e state, nextState;
  logic     svcDone;

  always_comb begin
    nextState = state;
    svcDone   = 1'b0;
    if (keyWr) begin
      case (state)
        ST_IDLE:    if (keyVal == KEY_OPEN && enBit) nextState = ST_PRE;
        ST_PRE:     if (keyVal == KEY_SEAL) nextState = ST_ACTIVE;
        ST_ACTIVE:  if (keyVal == KEY_OPEN) nextState = ST_SERVICE;
        ST_SERVICE: if (keyVal == KEY_SEAL) begin
                      nextState = ST_ACTIVE;
                      svcDone   = 1'b1;
                    end
        default:    nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    strb.locked   = (state != ST_IDLE);
    strb.armed    = (state == ST_ACTIVE) || (state == ST_SERVICE);
    strb.clrCount = svcDone;
  end
endmodule

// File: rtl/wdog64_dp.sv
module wdog64_dp
  import wdog64_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  input  ctrlStrb_t         strb,
  output logic [CNT_W-1:0]  countQ,
  output logic [CNT_W-1:0]  periodQ,
  output logic [1:0]        modeQ,
  output logic [3:0]        gctlQ,
  output logic              flagQ,
  output logic              rstReq
);
  localparam int HALF_W = CNT_W / 2;

  logic wrCntLo, wrCntHi, wrPrdLo, wrPrdHi, wrMode, wrGctl, wrWd;
  logic cfgOpen, running, expireHit;

  assign cfgOpen = busWe && !strb.locked;
  assign wrCntLo = cfgOpen && (busAddr == ADDR_W'(OFF_CNT_LO));
  assign wrCntHi = cfgOpen && (busAddr == ADDR_W'(OFF_CNT_HI));
  assign wrPrdLo = cfgOpen && (busAddr == ADDR_W'(OFF_PRD_LO));
  assign wrPrdHi = cfgOpen && (busAddr == ADDR_W'(OFF_PRD_HI));
  assign wrMode  = cfgOpen && (busAddr == ADDR_W'(OFF_MODE));
  assign wrGctl  = cfgOpen && (busAddr == ADDR_W'(OFF_GCTL));
  assign wrWd    = busWe && (busAddr == ADDR_W'(OFF_WDCTL));

  assign running   = (modeQ != 2'd0) && gctlQ[0] && gctlQ[1];
  assign expireHit = strb.armed && running && (countQ == periodQ) && !strb.clrCount;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      countQ <= '0;
    end else if (strb.clrCount || expireHit) begin
      countQ <= '0;
    end else if (wrCntLo) begin
      countQ[HALF_W-1:0] <= busWdata[HALF_W-1:0];
    end else if (wrCntHi) begin
      countQ[CNT_W-1:HALF_W] <= busWdata[HALF_W-1:0];
    end else if (running) begin
      countQ <= countQ + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      periodQ <= '0;
      modeQ   <= '0;
      gctlQ   <= '0;
    end else begin
      if (wrPrdLo) periodQ[HALF_W-1:0]     <= busWdata[HALF_W-1:0];
      if (wrPrdHi) periodQ[CNT_W-1:HALF_W] <= busWdata[HALF_W-1:0];
      if (wrMode)  modeQ <= busWdata[7:6];
      if (wrGctl)  gctlQ <= busWdata[3:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flagQ  <= 1'b0;
      rstReq <= 1'b0;
    end else begin
      rstReq <= expireHit;
      if (expireHit)                flagQ <= 1'b1;
      else if (wrWd && busWdata[15]) flagQ <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog64_keyed.sv
module wdog64_keyed
  import wdog64_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [31:0] ID_VALUE = 32'h5744_0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              rstReq
);
  localparam int CNT_W = 64;

  ctrlStrb_t        strb;
  logic [CNT_W-1:0] countQ, periodQ;
  logic [1:0]       modeQ;
  logic [3:0]       gctlQ;
  logic             flagQ;
  logic             keyWr;

  assign keyWr = busWe && (busAddr == ADDR_W'(OFF_WDCTL));

  wdog64_ctrl uCtrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .keyWr  (keyWr),
    .keyVal (busWdata[31:16]),
    .enBit  (busWdata[14]),
    .strb   (strb)
  );

  wdog64_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uDp (
    .clk      (clk),
    .rst_n    (rst_n),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busWdata (busWdata),
    .strb     (strb),
    .countQ   (countQ),
    .periodQ  (periodQ),
    .modeQ    (modeQ),
    .gctlQ    (gctlQ),
    .flagQ    (flagQ),
    .rstReq   (rstReq)
  );

  always_comb begin
    busRdata = '0;
    if      (busAddr == ADDR_W'(OFF_ID))     busRdata = ID_VALUE;
    else if (busAddr == ADDR_W'(OFF_CNT_LO)) busRdata = countQ[31:0];
    else if (busAddr == ADDR_W'(OFF_CNT_HI)) busRdata = countQ[63:32];
    else if (busAddr == ADDR_W'(OFF_PRD_LO)) busRdata = periodQ[31:0];
    else if (busAddr == ADDR_W'(OFF_PRD_HI)) busRdata = periodQ[63:32];
    else if (busAddr == ADDR_W'(OFF_MODE))   busRdata = {24'h0, modeQ, 6'h0};
    else if (busAddr == ADDR_W'(OFF_GCTL))   busRdata = {28'h0, gctlQ};
    else if (busAddr == ADDR_W'(OFF_WDCTL))  busRdata = {16'h0, flagQ, strb.locked, 14'h0};
  end
endmodule

// File: rtl/wdog64_chk.sv
module wdog64_chk
  import wdog64_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        rstReq,
  input ctrlStrb_t   strb,
  input logic [63:0] countQ,
  input logic [63:0] periodQ,
  input logic        flagQ
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rstReq && periodQ != 64'd0) |=> !rstReq); // R8
  AST_REQ_FLAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rstReq |-> (flagQ && countQ == 64'd0)); // R8
  AST_REQ_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    rstReq |-> strb.armed); // R10
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    strb.locked |=> strb.locked); // R7
  AST_PERIOD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.locked && $past(strb.locked)) |-> $stable(periodQ)); // R5
  AST_SERVICE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clrCount |=> (countQ == 64'd0)); // R6
endmodule

bind wdog64_keyed wdog64_chk uChk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rstReq  (rstReq),
  .strb    (strb),
  .countQ  (countQ),
  .periodQ (periodQ),
  .flagQ   (flagQ)
);

// File: tb/wdog64_keyed_test.sv
`timescale 1ns/1ps
module wdog64_keyed_test;
  localparam logic [31:0] ID_V = 32'h5744_0101;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rstReq;

  int nChk = 0;
  int nBad = 0;
  int reqCount = 0;
  bit finished = 0;

  wdog64_keyed #(.ADDR_W(8), .ID_VALUE(ID_V)) uut (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .rstReq(rstReq)
  );

  always #4 clk = ~clk;

  always @(negedge clk) if (rst_n && rstReq) reqCount++;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; busWe = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    reqCount = 0;
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic setup(input logic [31:0] prd);
    busWrite(8'h18, prd);
    busWrite(8'h1C, 32'h0);
    busWrite(8'h10, 32'h0);
    busWrite(8'h14, 32'h0);
    busWrite(8'h24, 32'h0000_000B);
    busWrite(8'h20, 32'h0000_0080);
  endtask

  task automatic arm();
    busWrite(8'h28, 32'hA5C6_4000);
    busWrite(8'h28, 32'hDA7E_0000);
  endtask

  task automatic service();
    busWrite(8'h28, 32'hA5C6_0000);
    busWrite(8'h28, 32'hDA7E_0000);
  endtask

  task automatic testResetRegs();
    logic [31:0] v;
    doReset();
    @(negedge clk);
    check("R1 rstReq", rstReq, 0);
    busRead(8'h00, v); check("R1 id", v, ID_V);
    busRead(8'h10, v); check("R1 cnt lo", v, 0);
    busRead(8'h1C, v); check("R1 prd hi", v, 0);
    busRead(8'h28, v); check("R1 wdctl", v, 0);
    busWrite(8'h18, 32'hDEAD_BEEF); busRead(8'h18, v); check("R2 prd lo", v, 32'hDEAD_BEEF);
    busWrite(8'h1C, 32'h1234_5678); busRead(8'h1C, v); check("R2 prd hi", v, 32'h1234_5678);
    busWrite(8'h14, 32'h0000_00AB); busRead(8'h14, v); check("R2 cnt hi", v, 32'hAB);
    busWrite(8'h20, 32'hFFFF_FFFF); busRead(8'h20, v); check("R2 mode", v, 32'hC0);
    busWrite(8'h24, 32'hFFFF_FFF4); busRead(8'h24, v); check("R2 gctl", v, 32'h4);
    busWrite(8'h04, 32'hFFFF_FFFF); busRead(8'h04, v); check("R2 emu", v, 0);
  endtask

  task automatic testCount();
    logic [31:0] a, b;
    doReset();
    busWrite(8'h10, 32'hFFFF_FFFE);
    busWrite(8'h20, 32'h0000_0080);
    busWrite(8'h24, 32'h0000_0001);
    busRead(8'h10, a); @(negedge clk); busRead(8'h10, b);
    check("R3 hold half reset", b, a);
    busWrite(8'h20, 32'h0);
    busWrite(8'h24, 32'h0000_0003);
    busRead(8'h10, a); @(negedge clk); busRead(8'h10, b);
    check("R3 hold mode 0", b, a);
    busWrite(8'h20, 32'h0000_0040);
    busRead(8'h10, a); check("R3 start", a, 32'hFFFF_FFFE);
    @(negedge clk); busRead(8'h10, a); check("R3 step", a, 32'hFFFF_FFFF);
    @(negedge clk); busRead(8'h10, a); busRead(8'h14, b);
    check("R3 carry lo", a, 0); check("R3 carry hi", b, 1);
  endtask

  task automatic testArmLock();
    logic [31:0] v;
    doReset();
    setup(32'd20);
    busWrite(8'h28, 32'hA5C6_0000);
    busRead(8'h28, v); check("R4 no enable bit", v[14], 0);
    busWrite(8'h18, 32'd7); busRead(8'h18, v); check("R4 still idle", v, 7);
    busWrite(8'h18, 32'd20);
    repeat (40) @(negedge clk);
    check("R10 idle no request", reqCount, 0);
    busWrite(8'h28, 32'hA5C6_4000);
    busRead(8'h28, v); check("R4 enable reads 1", v[14], 1);
    busWrite(8'h18, 32'd5); busRead(8'h18, v); check("R5 period locked", v, 20);
    busWrite(8'h24, 32'h0); busRead(8'h24, v); check("R5 gctl locked", v, 32'hB);
    busWrite(8'h20, 32'h0); busRead(8'h20, v); check("R5 mode locked", v, 32'h80);
    repeat (60) @(negedge clk);
    check("R10 pre-active no request", reqCount, 0);
  endtask

  task automatic testService();
    logic [31:0] v;
    doReset();
    setup(32'd1000);
    arm();
    repeat (10) @(negedge clk);
    busWrite(8'h28, 32'hDA7E_0000);
    busRead(8'h10, v); check("R7 out of order no clear", v != 0, 1);
    busWrite(8'h28, 32'h1234_0000);
    busWrite(8'h28, 32'hA5C6_0000);
    busWrite(8'h28, 32'h5555_0000);
    busRead(8'h10, v); check("R7 wrong key no clear", v != 0, 1);
    busWrite(8'h28, 32'hDA7E_0000);
    busRead(8'h10, v); check("R6 service clears", v, 0);
    busRead(8'h28, v); check("R7 still locked", v[14], 1);
    doReset();
    setup(32'd30);
    arm();
    for (int i = 0; i < 8; i++) begin
      repeat (20) @(negedge clk);
      service();
    end
    check("R6 serviced no request", reqCount, 0);
  endtask

  task automatic testExpire();
    logic [31:0] v;
    int c;
    doReset();
    setup(32'd20);
    arm();
    c = 0;
    while (!rstReq && c < 500) begin @(negedge clk); c++; end
    check("R8 first request seen", rstReq, 1);
    busRead(8'h10, v); check("R8 count zero", v, 0);
    @(negedge clk); check("R8 one cycle", rstReq, 0);
    c = 0;
    while (!rstReq && c < 500) begin @(negedge clk); c++; end
    check("R8 interval period+1", c + 1, 21);
    busRead(8'h28, v); check("R8 flag set", v[15], 1);
    busWrite(8'h28, 32'hA5C6_0000);
    busRead(8'h28, v); check("R9 key keeps flag", v[15], 1);
    busWrite(8'h28, 32'h0000_8000);
    busRead(8'h28, v); check("R9 w1c clears", v[15], 0);
  endtask

  initial begin
    testResetRegs();
    testCount();
    testArmLock();
    testService();
    testExpire();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      nChk++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule